// File: doc/BRIEF.md
# Chained Dual-Byte Interrupt Controller

The block gathers device interrupt requests behind two 8-bit controller stages on a byte-wide I/O port bus and drives a single interrupt line to the processor. A downstream stage takes eight request lines. It reports any of its enabled, pending requests into one input of the upstream stage. The upstream stage takes seven further device lines of its own, so fifteen device lines enter in total. The processor interrupt is raised while anything is pending and enabled on the upstream stage.

Software enables lines by writing each stage's enable register. Those registers cannot be read back, so software keeps its own copy. It finds which lines are active by reading the two pending registers. Taken together, the upstream pending byte forms the low half of a 16-bit interrupt view and the downstream byte forms the high half. Downstream line k therefore appears as system interrupt 8+k. Request inputs are active-high and asynchronous, and each passes through a two-flop synchronizer before it is gated by its enable bit.

Top module: `irq_cascade_ctl`

## Requirements
- R1: After a synchronous active-high reset, both enable registers are 0x00, both pending registers read 0x00 and `cpu_irq` is low.
- R2: A write to port 0x21 loads the upstream enable register and a write to port 0xA1 loads the downstream enable register. An enable bit of 1 lets the matching request line through and 0 blocks it.
- R3: A read of port 0x20 returns the upstream pending byte and a read of port 0xA0 returns the downstream pending byte. Each pending bit is the request line ANDed with its enable bit. A change on a request line shows in its pending bit on the third rising clock edge after the change.
- R4: A read of port 0x21, of port 0xA1, of any unmapped port, or any cycle with `io_rd` low returns 0x00 on `io_rdata`.
- R5: Writes to ports 0x20, 0xA0 or any unmapped port change neither enable register.
- R6: Upstream pending bit 2 is set, when upstream enable bit 2 is 1, one clock edge after any downstream pending bit is set, and it clears one edge after all downstream pending bits clear. The device input `up_req[2]` has no effect.
- R7: `cpu_irq` is high exactly when the upstream pending byte is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational from address |
| up_req | input | 8 | Upstream device requests, bit 2 ignored |
| dn_req | input | 8 | Downstream device requests |
| cpu_irq | output | 1 | Combined interrupt to the processor |

## Verification
The checker assumes that reset is held for at least one clock edge at the start and that the bus strobes are stable around each rising edge. Both strobes are treated as ordinary synchronous inputs. The request lines are treated as asynchronous, so the properties only relate pending bits to enable values and to the downstream summary, never to the raw request pins. The bench changes requests, addresses and strobes only at the falling edge. It holds requests steady for several cycles before it reads a pending register, except in the latency test, which counts the edges one by one.

// File: rtl/irq_cascade_ctl.sv
module irq_cascade_ctl #(
  parameter logic [7:0] UP_STAT_PORT = 8'h20,
  parameter logic [7:0] UP_EN_PORT   = 8'h21,
  parameter logic [7:0] DN_STAT_PORT = 8'hA0,
  parameter logic [7:0] DN_EN_PORT   = 8'hA1,
  parameter int         LINK_BIT     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  input  logic       io_rd,
  output logic [7:0] io_rdata,
  input  logic [7:0] up_req,
  input  logic [7:0] dn_req,
  output logic       cpu_irq
);
  localparam logic [7:0] LINK_MASK = 8'(1 << LINK_BIT);

  logic [7:0] up_en, dn_en;
  logic [7:0] up_s1, up_s2, dn_s1, dn_s2;
  logic [7:0] up_stat, dn_stat;
  logic       dn_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_en <= '0;
      dn_en <= '0;
    end else if (io_wr) begin
      if (io_addr == UP_EN_PORT) up_en <= io_wdata;
      if (io_addr == DN_EN_PORT) dn_en <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_s1 <= '0; up_s2 <= '0;
      dn_s1 <= '0; dn_s2 <= '0;
    end else begin
      up_s1 <= up_req & ~LINK_MASK;
      up_s2 <= up_s1;
      dn_s1 <= dn_req;
      dn_s2 <= dn_s1;
    end
  end

  assign dn_any = |dn_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_stat <= '0;
      dn_stat <= '0;
    end else begin
      dn_stat <= dn_s2 & dn_en;
      up_stat <= (up_s2 | (dn_any ? LINK_MASK : 8'h00)) & up_en;
    end
  end

  assign cpu_irq = |up_stat;

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (io_addr == UP_STAT_PORT)      io_rdata = up_stat;
      else if (io_addr == DN_STAT_PORT) io_rdata = dn_stat;
    end
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] io_addr,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic       io_rd,
  input logic [7:0] io_rdata,
  input logic       cpu_irq,
  input logic [7:0] up_en,
  input logic [7:0] dn_en,
  input logic [7:0] up_stat,
  input logic [7:0] dn_stat
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (up_stat == 8'h00 && dn_stat == 8'h00 && up_en == 8'h00 && dn_en == 8'h00)); // R1
  AST_UP_EN_LOAD: assert property (@(posedge clk) disable iff (rst) (io_wr && io_addr == 8'h21) |=> up_en == $past(io_wdata)); // R2
  AST_DN_EN_LOAD: assert property (@(posedge clk) disable iff (rst) (io_wr && io_addr == 8'hA1) |=> dn_en == $past(io_wdata)); // R2
  AST_DN_GATED: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (dn_stat & ~$past(dn_en)) == 8'h00); // R3
  AST_UP_GATED: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (up_stat & ~$past(up_en)) == 8'h00); // R3
  AST_EN_HIDDEN: assert property (@(posedge clk) disable iff (rst) (io_addr == 8'h21 || io_addr == 8'hA1 || !io_rd) |-> io_rdata == 8'h00); // R4
  AST_EN_KEPT: assert property (@(posedge clk) disable iff (rst) (io_wr && io_addr != 8'h21 && io_addr != 8'hA1) |=> ($stable(up_en) && $stable(dn_en))); // R5
  AST_LINK_SET: assert property (@(posedge clk) disable iff (rst) ((dn_stat != 8'h00) && up_en[2]) |=> up_stat[2]); // R6
  AST_LINK_CLEAR: assert property (@(posedge clk) disable iff (rst) (dn_stat == 8'h00) |=> !up_stat[2]); // R6
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst) (io_rd && io_addr == 8'h20) |-> ((io_rdata != 8'h00) == cpu_irq)); // R7
endmodule

bind irq_cascade_ctl irq_cascade_chk u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rd(io_rd), .io_rdata(io_rdata), .cpu_irq(cpu_irq),
  .up_en(up_en), .dn_en(dn_en), .up_stat(up_stat), .dn_stat(dn_stat)
);

// File: tb/irq_cascade_ctl_bench.sv
module irq_cascade_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic       io_rd = 1'b0;
  logic [7:0] io_rdata;
  logic [7:0] up_req = 8'h00;
  logic [7:0] dn_req = 8'h00;
  logic       cpu_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_cascade_ctl u_irq_cascade_ctl (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_rdata(io_rdata), .up_req(up_req), .dn_req(dn_req), .cpu_irq(cpu_irq)
  );

  // {up_en, dn_en, up_req, dn_req, exp_up, exp_dn}
  localparam logic [47:0] VEC [7] = '{
    {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFB, 8'h00},
    {8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF},
    {8'h04, 8'h02, 8'h00, 8'h02, 8'h04, 8'h02},
    {8'h04, 8'h02, 8'h00, 8'hFD, 8'h00, 8'h00},
    {8'h0F, 8'hF0, 8'h05, 8'h30, 8'h05, 8'h30},
    {8'hA5, 8'h5A, 8'h5A, 8'hA5, 8'h00, 8'h00},
    {8'h80, 8'h00, 8'h84, 8'h00, 8'h80, 8'h00}
  };

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0; io_addr = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    rd(8'h20, v); check8("R1", "up pending after reset", v, 8'h00);
    rd(8'hA0, v); check8("R1", "dn pending after reset", v, 8'h00);
    check8("R1", "cpu_irq after reset", {7'b0, cpu_irq}, 8'h00);

    for (int k = 0; k < 7; k++) begin
      wr(8'h21, VEC[k][47:40]);
      wr(8'hA1, VEC[k][39:32]);
      up_req = VEC[k][31:24];
      dn_req = VEC[k][23:16];
      idle(6);
      rd(8'h20, v); check8("R3", $sformatf("vec%0d up pending", k), v, VEC[k][15:8]);
      rd(8'hA0, v); check8("R6", $sformatf("vec%0d dn pending", k), v, VEC[k][7:0]);
      check8("R7", $sformatf("vec%0d cpu_irq", k), {7'b0, cpu_irq}, {7'b0, VEC[k][15:8] != 8'h00});
    end

    // R4: enable ports hidden, unmapped reads zero
    wr(8'h21, 8'hFF); wr(8'hA1, 8'hFF);
    up_req = 8'h00; dn_req = 8'hFF; idle(6);
    rd(8'h21, v); check8("R4", "up enable port read", v, 8'h00);
    rd(8'hA1, v); check8("R4", "dn enable port read", v, 8'h00);
    rd(8'h22, v); check8("R4", "unmapped read", v, 8'h00);
    check8("R4", "rdata with io_rd low", io_rdata, 8'h00);

    // R5: writes to pending and unmapped ports leave enables alone
    wr(8'h21, 8'h00); wr(8'hA1, 8'h00);
    up_req = 8'hFF; dn_req = 8'hFF;
    wr(8'h20, 8'hFF); wr(8'hA0, 8'hFF); wr(8'h30, 8'hFF); wr(8'h61, 8'hFF);
    idle(6);
    rd(8'h20, v); check8("R5", "up pending after stray writes", v, 8'h00);
    rd(8'hA0, v); check8("R5", "dn pending after stray writes", v, 8'h00);

    // R3: latency of three edges
    up_req = 8'h00; dn_req = 8'h00;
    wr(8'h21, 8'hFF); wr(8'hA1, 8'hFF); idle(5);
    up_req = 8'h01;
    idle(2); rd(8'h20, v); check8("R3", "pending after two edges", v, 8'h00);
    idle(1); rd(8'h20, v); check8("R3", "pending after three edges", v, 8'h01);

    // R6: link bit one edge behind downstream pending
    up_req = 8'h00; idle(5);
    dn_req = 8'h40;
    idle(3); rd(8'hA0, v); check8("R6", "dn pending at third edge", v, 8'h40);
    rd(8'h20, v); check8("R6", "link not yet set", v, 8'h00);
    idle(1); rd(8'h20, v); check8("R6", "link set next edge", v, 8'h04);
    dn_req = 8'h00;
    idle(4); rd(8'h20, v); check8("R6", "link cleared", v, 8'h00);

    // R6: up_req[2] has no effect
    wr(8'h21, 8'h04); up_req = 8'h04; idle(6);
    rd(8'h20, v); check8("R6", "up_req[2] ignored", v, 8'h00);
    check8("R7", "cpu_irq low with only up_req[2]", {7'b0, cpu_irq}, 8'h00);

    // R1: reset mid-run clears enables
    wr(8'h21, 8'hFF); wr(8'hA1, 8'hFF); up_req = 8'hFF; dn_req = 8'hFF; idle(6);
    rst = 1'b1; idle(2); rst = 1'b0; idle(6);
    rd(8'h20, v); check8("R1", "up pending after second reset", v, 8'h00);
    rd(8'hA0, v); check8("R1", "dn pending after second reset", v, 8'h00);
    check8("R1", "cpu_irq after second reset", {7'b0, cpu_irq}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule